// File: doc/BRIEF.md
# Pending Message-Interrupt Priority Scanner

This block keeps track of the best pending message-signalled interrupt for one processor. The pending state is held in memory as a bitmap, with one bit per interrupt ID. A second table, also in memory, holds one configuration byte per interrupt, which carries an enable bit and a priority field. The block reaches both tables through a single byte-wide memory port. The request and response sides of that port each use a valid/ready handshake. The block reports the winning interrupt ID, its priority and a valid flag. The winner always belongs to the non-secure group 1 class, so no group output is needed.

Software or a neighbouring block sends three kinds of command through a valid/ready command port:
- A full rescan walks the whole pending bitmap.
- A set-pending command does a read-modify-write on one bitmap byte and then compares only the new interrupt against the current winner.
- A clear-pending command does the same read-modify-write. It starts a full rescan only if the cleared ID is the current winner.

The enable, base-address, ID-width and security inputs are plain levels. They must stay stable while `busy` is high.

Memory port rules:
- A request stays asserted, with address, write flag and write data unchanged, until `mem_req_ready` is seen high.
- Only one read is outstanding at a time.
- `mem_rsp_ready` is high only while the block waits for read data.
- Writes return no response.

Top module: `lpi_pend_scan`

## Requirements
- R1: Out of reset, `busy` is low, `req_ready` is high, `best_valid` is low and no memory request is driven.
- R2: A command has no memory traffic and no effect on the outputs unless `lpi_en` is high and both `prop_base` and `pend_base` are non-zero.
- R3: The effective ID width is the smaller of `id_bits` and ID_CAP (13). The table covers 2^(width+1) IDs. A set or clear command whose ID is below 8192 or above the last table ID is ignored, with no memory traffic.
- R4: A rescan (`req_op` = 0) first sets the best priority to 0xFF. It then reads the pending bytes at `pend_base + i`, for i from 1024 up to the last table byte. Bit b of byte i stands for ID 8*i+b, and the bits of each byte are visited from lowest to highest.
- R5: For each pending ID, the configuration byte at `prop_base + (ID - 8192)` is read. Bit 0 is the enable bit and bits 7:2 are the priority field. An entry with a clear enable bit is skipped.
- R6: With `sec_dis` high, the priority is the byte ANDed with 0xFC. With `sec_dis` low, it is (byte AND 0xFC) shifted right by one, ORed with 0x80.
- R7: A candidate wins over the current best if its priority is lower, or if the priorities are equal and its ID is lower or equal. A lower priority value means a more urgent interrupt.
- R8: A set command (`req_op` = 1) reads the pending byte that holds the ID and writes it back with the bit set. If the bit was already set, no write occurs and the best is unchanged.
- R9: After a set command, only the new ID's configuration byte is read and compared. The pending table is not scanned.
- R10: A clear command (`req_op` = 2) writes the pending byte back with the bit cleared, skipping the write if the bit is already clear. A rescan follows only if the ID equals the current best ID. Otherwise the best is left unchanged.
- R11: `best_valid` is low while `busy` is high and whenever the best priority is 0xFF.
- R12: A memory request is held stable until it is accepted. Read data is taken only while `mem_rsp_ready` is high.
- R13: `busy` is high from the cycle after a command is accepted until that command has finished. `req_ready` equals the inverse of `busy`. `req_op` = 3 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lpi_en | input | 1 | Message-interrupt enable |
| sec_dis | input | 1 | Security disabled; selects the priority view |
| id_bits | input | 5 | Programmed ID-width field |
| prop_base | input | ADDR_W | Byte address of the configuration table |
| pend_base | input | ADDR_W | Byte address of the pending bitmap |
| req_valid | input | 1 | Command valid |
| req_ready | output | 1 | Command accepted when high with `req_valid` |
| req_op | input | 2 | 0 rescan, 1 set, 2 clear, 3 none |
| req_id | input | ID_W | Interrupt ID for set and clear |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | ADDR_W | Byte address |
| mem_req_wdata | output | 8 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Block is waiting for read data |
| mem_rsp_data | input | 8 | Read data |
| busy | output | 1 | Command in progress |
| best_valid | output | 1 | Best ID and priority are meaningful |
| best_id | output | ID_W | Best pending interrupt ID |
| best_prio | output | 8 | Priority of the best ID |

## Verification
The bench targets the points where a slip is cheap to make and easy to miss:
- **Equal-priority ties.** A design that breaks ties the wrong way reports the higher ID.
- **Disabled configuration entries.** A design that ignores bit 0 promotes a disabled interrupt.
- **Security-on priority mapping.** A design that skips the shift and OR reports raw field values.
- **Set of an already pending bit.** A design that writes anyway, or that compares again, shows up in the write count and in the outputs.
- **Clear of a non-winner.** A design that always rescans shows 1024 extra pending reads.
- **Clear of the winner.** A design that never rescans keeps reporting a cleared interrupt.
- **ID-width clamp and range checks.** A design without the clamp, or without the range check, either scans an empty range or issues traffic for IDs below 8192.

A swept set of pseudo-random tables, with both security settings, is compared against an arithmetic model of the winner.

// File: rtl/lpi_scan_pkg.sv
package lpi_scan_pkg;

  typedef enum logic [1:0] {
    LPI_OP_RESCAN = 2'd0,
    LPI_OP_SET    = 2'd1,
    LPI_OP_CLEAR  = 2'd2,
    LPI_OP_NONE   = 2'd3
  } lpi_op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PEND_REQ,
    ST_PEND_WAIT,
    ST_PEND_BIT,
    ST_CFG_REQ,
    ST_CFG_WAIT,
    ST_MOD_REQ,
    ST_MOD_WAIT,
    ST_MOD_WRITE
  } lpi_state_e;

  localparam logic [7:0] PRIO_NONE  = 8'hFF;
  localparam logic [7:0] PRIO_FIELD = 8'hFC;

  // Priority as seen by the comparison, per security setting.
  function automatic logic [7:0] lpi_view_prio(input logic [7:0] cfg, input logic sec_off);
    logic [7:0] field;
    field = cfg & PRIO_FIELD;
    return sec_off ? field : ((field >> 1) | 8'h80);
  endfunction

endpackage

// File: rtl/lpi_id_window.sv
module lpi_id_window #(
  parameter int ID_CAP   = 13,
  parameter int FIRST_ID = 8192,
  localparam int ID_W    = ID_CAP + 1,
  localparam int BI_W    = ID_W - 3
) (
  input  logic [4:0]      id_bits,
  input  logic [ID_W-1:0] chk_id,
  output logic [BI_W-1:0] last_byte,
  output logic            has_lpis,
  output logic            in_range
);
  logic [4:0]    eff;
  logic [ID_W:0] tbl_ids;

  always_comb begin
    eff       = (int'(id_bits) > ID_CAP) ? 5'(ID_CAP) : id_bits;
    tbl_ids   = (ID_W + 1)'(1) << (eff + 5'd1);
    has_lpis  = tbl_ids > (ID_W + 1)'(FIRST_ID);
    last_byte = BI_W'((tbl_ids >> 3) - (ID_W + 1)'(1));
    in_range  = (chk_id >= ID_W'(FIRST_ID)) && ({1'b0, chk_id} < tbl_ids);
  end
endmodule

// File: rtl/lpi_low_bit.sv
module lpi_low_bit #(
  parameter int W   = 8,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] pos
);
  always_comb begin
    pos = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) pos = IW'(i);
    end
  end
endmodule

// File: rtl/lpi_prio_cmp.sv
module lpi_prio_cmp #(
  parameter int ID_W = 14
) (
  input  logic [7:0]      cand_prio,
  input  logic [ID_W-1:0] cand_id,
  input  logic [7:0]      best_prio,
  input  logic [ID_W-1:0] best_id,
  output logic            take
);
  always_comb begin
    take = (cand_prio < best_prio) || ((cand_prio == best_prio) && (cand_id <= best_id));
  end
endmodule

// File: rtl/lpi_pend_scan.sv
module lpi_pend_scan
  import lpi_scan_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int ID_CAP   = 13,
  parameter int FIRST_ID = 8192,
  localparam int ID_W    = ID_CAP + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lpi_en,
  input  logic              sec_dis,
  input  logic [4:0]        id_bits,
  input  logic [ADDR_W-1:0] prop_base,
  input  logic [ADDR_W-1:0] pend_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ID_W-1:0]   req_id,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [7:0]        mem_req_wdata,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [7:0]        mem_rsp_data,
  output logic              busy,
  output logic              best_valid,
  output logic [ID_W-1:0]   best_id,
  output logic [7:0]        best_prio
);
  localparam int BI_W = ID_W - 3;
  localparam logic [BI_W-1:0] START_BYTE = BI_W'(FIRST_ID / 8);

  lpi_state_e      st;
  logic [BI_W-1:0] byte_idx;
  logic [7:0]      pend_byte;
  logic [ID_W-1:0] cur_id;
  logic            single_cmp;
  logic            mod_set;

  logic            active;
  logic [BI_W-1:0] last_byte;
  logic            has_lpis;
  logic            in_range;
  logic [2:0]      low_pos;
  logic [7:0]      cand_prio;
  logic            take;
  logic [7:0]      bit_mask;
  logic            bit_now;

  lpi_id_window #(.ID_CAP(ID_CAP), .FIRST_ID(FIRST_ID)) u_window (
    .id_bits  (id_bits),
    .chk_id   (req_id),
    .last_byte(last_byte),
    .has_lpis (has_lpis),
    .in_range (in_range)
  );

  lpi_low_bit #(.W(8)) u_low (
    .vec(pend_byte),
    .pos(low_pos)
  );

  lpi_prio_cmp #(.ID_W(ID_W)) u_cmp (
    .cand_prio(cand_prio),
    .cand_id  (cur_id),
    .best_prio(best_prio),
    .best_id  (best_id),
    .take     (take)
  );

  always_comb begin
    active    = lpi_en && (|prop_base) && (|pend_base);
    cand_prio = lpi_view_prio(mem_rsp_data, sec_dis);
    bit_mask  = 8'h01 << cur_id[2:0];
    bit_now   = |(mem_rsp_data & bit_mask);

    busy          = (st != ST_IDLE);
    req_ready     = !busy;
    best_valid    = !busy && (best_prio != PRIO_NONE);
    mem_req_valid = (st == ST_PEND_REQ) || (st == ST_CFG_REQ) ||
                    (st == ST_MOD_REQ)  || (st == ST_MOD_WRITE);
    mem_req_we    = (st == ST_MOD_WRITE);
    mem_rsp_ready = (st == ST_PEND_WAIT) || (st == ST_CFG_WAIT) || (st == ST_MOD_WAIT);
    mem_req_wdata = pend_byte;
    case (st)
      ST_PEND_REQ: mem_req_addr = pend_base + ADDR_W'(byte_idx);
      ST_CFG_REQ:  mem_req_addr = prop_base + ADDR_W'(cur_id - ID_W'(FIRST_ID));
      default:     mem_req_addr = pend_base + ADDR_W'(cur_id[ID_W-1:3]);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      byte_idx   <= '0;
      pend_byte  <= '0;
      cur_id     <= '0;
      single_cmp <= 1'b0;
      mod_set    <= 1'b0;
      best_id    <= '0;
      best_prio  <= PRIO_NONE;
    end else begin
      case (st)
        ST_IDLE: begin
          if (req_valid && active) begin
            case (lpi_op_e'(req_op))
              LPI_OP_RESCAN: begin
                best_prio <= PRIO_NONE;
                byte_idx  <= START_BYTE;
                if (has_lpis) st <= ST_PEND_REQ;
              end
              LPI_OP_SET, LPI_OP_CLEAR: begin
                if (in_range) begin
                  cur_id  <= req_id;
                  mod_set <= (lpi_op_e'(req_op) == LPI_OP_SET);
                  st      <= ST_MOD_REQ;
                end
              end
              default: ;
            endcase
          end
        end
        ST_PEND_REQ:  if (mem_req_ready) st <= ST_PEND_WAIT;
        ST_PEND_WAIT: begin
          if (mem_rsp_valid) begin
            pend_byte <= mem_rsp_data;
            st        <= ST_PEND_BIT;
          end
        end
        ST_PEND_BIT: begin
          if (pend_byte == 8'h00) begin
            if (byte_idx == last_byte) begin
              st <= ST_IDLE;
            end else begin
              byte_idx <= byte_idx + 1'b1;
              st       <= ST_PEND_REQ;
            end
          end else begin
            cur_id     <= {byte_idx, low_pos};
            pend_byte  <= pend_byte & ~(8'h01 << low_pos);
            single_cmp <= 1'b0;
            st         <= ST_CFG_REQ;
          end
        end
        ST_CFG_REQ:  if (mem_req_ready) st <= ST_CFG_WAIT;
        ST_CFG_WAIT: begin
          if (mem_rsp_valid) begin
            if (mem_rsp_data[0] && take) begin
              best_id   <= cur_id;
              best_prio <= cand_prio;
            end
            st <= single_cmp ? ST_IDLE : ST_PEND_BIT;
          end
        end
        ST_MOD_REQ:  if (mem_req_ready) st <= ST_MOD_WAIT;
        ST_MOD_WAIT: begin
          if (mem_rsp_valid) begin
            if (bit_now == mod_set) begin
              st <= ST_IDLE;
            end else begin
              pend_byte <= mod_set ? (mem_rsp_data | bit_mask) : (mem_rsp_data & ~bit_mask);
              st        <= ST_MOD_WRITE;
            end
          end
        end
        ST_MOD_WRITE: begin
          if (mem_req_ready) begin
            if (mod_set) begin
              single_cmp <= 1'b1;
              st         <= ST_CFG_REQ;
            end else if (cur_id == best_id) begin
              best_prio <= PRIO_NONE;
              byte_idx  <= START_BYTE;
              st        <= ST_PEND_REQ;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lpi_pend_scan_chk.sv
module lpi_pend_scan_chk #(
  parameter int ADDR_W   = 32,
  parameter int ID_CAP   = 13,
  parameter int FIRST_ID = 8192,
  localparam int ID_W    = ID_CAP + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lpi_en,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_op,
  input logic [ID_W-1:0]   req_id,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_we,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [7:0]        mem_req_wdata,
  input logic              mem_rsp_valid,
  input logic              mem_rsp_ready,
  input logic              busy,
  input logic              best_valid,
  input logic [ID_W-1:0]   best_id,
  input logic [7:0]        best_prio
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr) &&
      $stable(mem_req_we) && $stable(mem_req_wdata))); // R12

  AST_RSP_EXPECTED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> mem_rsp_ready); // R12

  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !lpi_en) |=> !busy); // R2

  AST_LOW_ID_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_op != 2'd0) && (req_id < ID_W'(FIRST_ID))) |=> !busy); // R3

  AST_VALID_SANE: assert property (@(posedge clk) disable iff (!rst_n)
    best_valid |-> ((best_prio != 8'hFF) && (best_id >= ID_W'(FIRST_ID)) && !busy)); // R11

  AST_IDLE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !req_valid) |=> (!busy && $stable(best_id) && $stable(best_prio))); // R13
endmodule

bind lpi_pend_scan lpi_pend_scan_chk #(
  .ADDR_W(ADDR_W), .ID_CAP(ID_CAP), .FIRST_ID(FIRST_ID)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lpi_en       (lpi_en),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_op       (req_op),
  .req_id       (req_id),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_we   (mem_req_we),
  .mem_req_addr (mem_req_addr),
  .mem_req_wdata(mem_req_wdata),
  .mem_rsp_valid(mem_rsp_valid),
  .mem_rsp_ready(mem_rsp_ready),
  .busy         (busy),
  .best_valid   (best_valid),
  .best_id      (best_id),
  .best_prio    (best_prio)
);

// File: tb/lpi_pend_scan_tb.sv
`timescale 1ns/1ps
module lpi_pend_scan_tb;
  localparam int ADDR_W = 32;
  localparam int ID_CAP = 13;
  localparam int ID_W   = ID_CAP + 1;
  localparam int FIRST  = 8192;
  localparam int PB     = 32'h0400;
  localparam int CB     = 32'h1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lpi_en = 1'b0, sec_dis = 1'b1;
  logic [4:0] id_bits = 5'd13;
  logic [ADDR_W-1:0] prop_base = ADDR_W'(CB), pend_base = ADDR_W'(PB);
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [ID_W-1:0] req_id = '0;
  logic req_ready, mem_req_valid, mem_req_ready, mem_req_we, mem_rsp_valid, mem_rsp_ready;
  logic [ADDR_W-1:0] mem_req_addr;
  logic [7:0] mem_req_wdata, mem_rsp_data;
  logic busy, best_valid;
  logic [ID_W-1:0] best_id;
  logic [7:0] best_prio;

  int checks = 0, errors = 0;
  int rd_pend = 0, rd_cfg = 0, wr_cnt = 0;

  always #10 clk = ~clk;

  lpi_pend_scan #(.ADDR_W(ADDR_W), .ID_CAP(ID_CAP), .FIRST_ID(FIRST)) u_dut (
    .clk(clk), .rst_n(rst_n), .lpi_en(lpi_en), .sec_dis(sec_dis), .id_bits(id_bits),
    .prop_base(prop_base), .pend_base(pend_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_id(req_id),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .busy(busy), .best_valid(best_valid), .best_id(best_id), .best_prio(best_prio)
  );

  // Memory model with periodic back-pressure and one-cycle read latency.
  logic [7:0] mem [0:16383];
  logic [1:0] stall = 2'd0;
  logic poke_en = 1'b0;
  logic [1:0] poke_kind = 2'd0;
  logic [13:0] poke_addr = '0;
  logic [7:0] poke_data = '0;

  assign mem_req_ready = (stall != 2'd3);

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16384; i++) mem[i] <= 8'h00;
      stall <= 2'd0;
      mem_rsp_valid <= 1'b0;
      mem_rsp_data <= 8'h00;
    end else begin
      stall <= stall + 2'd1;
      mem_rsp_valid <= 1'b0;
      if (poke_en) begin
        case (poke_kind)
          2'd0: mem[poke_addr] <= poke_data;
          2'd1: mem[poke_addr] <= mem[poke_addr] | poke_data;
          default: for (int i = PB + 1024; i < PB + 2048; i++) mem[i] <= 8'h00;
        endcase
      end
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_we) begin
          mem[mem_req_addr[13:0]] <= mem_req_wdata;
          wr_cnt <= wr_cnt + 1;
        end else begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data <= mem[mem_req_addr[13:0]];
          if (int'(mem_req_addr) < CB) rd_pend <= rd_pend + 1;
          else rd_cfg <= rd_cfg + 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic poke(input int kind, input int addr, input int data);
    @(negedge clk);
    poke_en = 1'b1; poke_kind = 2'(kind); poke_addr = 14'(addr); poke_data = 8'(data);
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic set_entry(input int id, input int cfg);
    poke(0, CB + id - FIRST, cfg);
    poke(1, PB + id / 8, 1 << (id % 8));
  endtask

  task automatic issue(input int op, input int id);
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_id = ID_W'(id);
    @(negedge clk);
    req_valid = 1'b0;
    while (busy) @(negedge clk);
  endtask

  // Arithmetic model: lowest priority value, then lowest ID.
  function automatic logic [21:0] model_best(input logic sd, input int eff);
    logic [7:0] bp = 8'hFF, c, p;
    int bid = 0;
    for (int id = FIRST; id < (1 << (eff + 1)); id++) begin
      if (mem[PB + id / 8][id % 8]) begin
        c = mem[CB + id - FIRST];
        if (c[0]) begin
          p = sd ? (c & 8'hFC) : (((c & 8'hFC) >> 1) | 8'h80);
          if (p < bp) begin bp = p; bid = id; end
        end
      end
    end
    return {bp, 14'(bid)};
  endfunction

  task automatic check_best(input string tag);
    logic [21:0] m;
    m = model_best(sec_dis, 13);
    if (m[21:14] == 8'hFF) chk(best_valid == 1'b0, {tag, " valid"}, best_valid, 0);
    else begin
      chk(best_valid == 1'b1, {tag, " valid"}, best_valid, 1);
      chk(best_id == m[13:0], {tag, " id"}, best_id, m[13:0]);
      chk(best_prio == m[21:14], {tag, " prio"}, best_prio, m[21:14]);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R13 watchdog: actual busy expected idle");
    finish_run();
  end

  initial begin
    int p0, c0, w0;
    logic [31:0] s;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(busy == 0 && req_ready == 1, "R1 busy/ready", busy, 0);
    chk(best_valid == 0 && mem_req_valid == 0, "R1 valid/mem", {best_valid, mem_req_valid}, 0);

    lpi_en = 1'b1; sec_dis = 1'b1; id_bits = 5'd13;
    // R4 R12: empty table scans every pending byte exactly once despite stalls
    p0 = rd_pend; c0 = rd_cfg;
    issue(0, 0);
    chk(rd_pend - p0 == 1024, "R4 R12 pend reads", rd_pend - p0, 1024);
    chk(rd_cfg == c0 && best_valid == 0, "R4 empty", best_valid, 0);

    // R5 R7: disabled entry skipped, tie goes to lower ID
    set_entry(8200, 8'h41); set_entry(9000, 8'h21); set_entry(12000, 8'h21); set_entry(8193, 8'h10);
    c0 = rd_cfg;
    issue(0, 0);
    chk(rd_cfg - c0 == 4, "R5 cfg reads", rd_cfg - c0, 4);
    chk(best_id == 14'(9000) && best_prio == 8'h20, "R7 tie winner", best_id, 9000);
    check_best("R5");

    // R6: security view of the priority
    sec_dis = 1'b0;
    issue(0, 0);
    chk(best_prio == 8'h90, "R6 secure prio", best_prio, 8'h90);

    // R11 R13: outputs during a scan
    @(negedge clk); req_valid = 1'b1; req_op = 2'd0;
    @(negedge clk); req_valid = 1'b0;
    repeat (5) @(negedge clk);
    chk(busy && !req_ready && !best_valid, "R11 R13 mid-scan", {busy, req_ready, best_valid}, 3'b100);
    while (busy) @(negedge clk);

    // R8 R9: set new ID, single compare
    poke(0, CB + 3, 8'h09);
    p0 = rd_pend; c0 = rd_cfg; w0 = wr_cnt;
    issue(1, 8195);
    chk(mem[PB + 1024] == 8'h0A, "R8 byte written", mem[PB + 1024], 8'h0A);
    chk(rd_pend - p0 == 1 && rd_cfg - c0 == 1 && wr_cnt - w0 == 1, "R9 traffic",
        (rd_pend - p0) * 256 + (rd_cfg - c0) * 16 + wr_cnt - w0, 12'h111);
    chk(best_id == 14'(8195) && best_prio == 8'h84, "R9 new best", best_prio, 8'h84);

    // R8: set again, no write
    w0 = wr_cnt; c0 = rd_cfg;
    issue(1, 8195);
    chk(wr_cnt == w0 && rd_cfg == c0, "R8 no rewrite", wr_cnt - w0, 0);
    chk(best_id == 14'(8195) && best_valid, "R8 best kept", best_id, 8195);

    // R10: clear non-winner, no rescan
    p0 = rd_pend;
    issue(2, 9000);
    chk(mem[PB + 1125] == 8'h00 && rd_pend - p0 == 1, "R10 clear other", rd_pend - p0, 1);
    chk(best_id == 14'(8195) && best_prio == 8'h84, "R10 best kept", best_id, 8195);

    // R10: clear winner, rescan
    p0 = rd_pend;
    issue(2, 8195);
    chk(rd_pend - p0 == 1025, "R10 rescan reads", rd_pend - p0, 1025);
    chk(best_id == 14'(12000) && best_prio == 8'h90, "R10 new winner", best_id, 12000);

    // R3: out-of-range and clamp
    p0 = rd_pend; w0 = wr_cnt;
    issue(1, 100);
    chk(rd_pend == p0 && wr_cnt == w0 && best_id == 14'(12000), "R3 low id ignored", rd_pend - p0, 0);
    id_bits = 5'd12;
    issue(1, 9000);
    chk(rd_pend == p0 && wr_cnt == w0, "R3 id above table", rd_pend - p0, 0);
    issue(0, 0);
    chk(rd_pend == p0 && best_valid == 0, "R3 empty window", best_valid, 0);
    id_bits = 5'd31;
    issue(0, 0);
    chk(rd_pend - p0 == 1024, "R3 clamp reads", rd_pend - p0, 1024);
    check_best("R3 clamp");

    // R2: inactive configurations
    id_bits = 5'd13;
    lpi_en = 1'b0; p0 = rd_pend;
    issue(1, 9000);
    chk(rd_pend == p0 && best_id == 14'(12000), "R2 disabled", rd_pend - p0, 0);
    lpi_en = 1'b1; prop_base = '0;
    issue(0, 0);
    chk(rd_pend == p0 && best_valid && best_id == 14'(12000), "R2 zero base", rd_pend - p0, 0);
    prop_base = ADDR_W'(CB);
    issue(3, 9000);
    chk(rd_pend == p0 && !busy, "R13 no-op", rd_pend - p0, 0);

    // Sweep of pseudo-random tables: R4 R5 R6 R7 R9 R10
    s = 32'h1234_5678;
    for (int r = 0; r < 10; r++) begin
      poke(2, 0, 0);
      sec_dis = r[0];
      for (int k = 0; k < 6; k++) begin
        s = s * 32'd1103515245 + 32'd12345;
        set_entry(FIRST + int'(s[25:13]), {s[7:2], 1'b0, (k != 2)});
      end
      issue(0, 0);
      check_best("R7 sweep scan");
      s = s * 32'd1103515245 + 32'd12345;
      poke(0, CB + int'(s[25:13]), {s[7:2], 2'b01});
      issue(1, FIRST + int'(s[25:13]));
      check_best("R9 sweep set");
      if (best_valid) begin
        issue(2, int'(best_id));
        check_best("R10 sweep clear");
      end
    end

    finish_run();
  end
endmodule